// File: doc/BRIEF.md
# Serial Flash Programming Slave

This block lets an external programmer load and inspect a 4 KB code array over a three-wire serial link: a shift clock, a data input and a data output. The programmer first raises a programming-mode input. It then sends frames most-significant bit first. Each frame starts with an opcode byte and an address-high byte.

The block decodes each frame and drives an internal memory port to a behavioural byte array. It models the self-timed erase and write with counters whose lengths are parameters. It also keeps a lock level that restricts what the programmer may do.

The serial inputs are synchronised with two flops into the system clock domain. Edges are detected there, so the shift clock must run at no more than one sixteenth of the system clock.

Most instructions are four bytes long. The two page instructions carry 256 data bytes after their two header bytes.

Top module: `isp_slave`

## Requirements
- R1: Until the enable frame has been accepted since the programming-mode input last rose, every other instruction has no effect and all read data on the output is 0x00.
- R2: The enable frame is 0xAC, 0x53 and two free bytes. The output shifts 0x69 during the fourth byte, and the block is enabled from the end of that frame.
- R3: The input is sampled on shift-clock rising edges and the output changes after falling edges, MSB first. Byte read is 0x20 and byte write is 0x40. The code address is {second byte bits 3:0, third byte}, and the fourth byte carries the data.
- R4: Page write (0x50) and page read (0x30) take the page number in bits 3:0 of the second byte. The next 256 bytes are offsets 0 to 255 of that page, and the byte after them is decoded as a new opcode.
- R5: Chip erase is 0xAC with a second byte of the form 100x_xxxx. It sets every byte to 0xFF, returns the lock level to 1, and raises busy for max(ERASE_CYC, 4096) clocks. Code reads during the erase return 0x00.
- R6: After a byte write, or after the last byte of a page write, busy stays high for WRITE_CYC clocks. During that time a read of the last address written returns the new byte with bit 7 inverted, and other addresses read normally.
- R7: While busy is high, byte writes, page-write data, chip erase and lock writes have no effect.
- R8: Lock write is 0xAC with a second byte of 1110_00ab, which requests lock level 1 + {a,b}. The level only rises, except through chip erase. Lock read is 0x24 and returns bit 2 set at level 2 or above, bit 3 at level 3 or above, bit 4 at level 4, and 0 in every other bit.
- R9: At lock level 2 or above, code writes are ignored and start no busy time. At level 3 or above, code reads and signature reads return 0x00.
- R10: Signature read is 0x28 with the same address fields as a byte read. It returns 0x1E at 0x000, 0x51 at 0x100, 0x06 at 0x200, and 0x00 at any other address.
- R11: A shift-clock rise fewer than GUARD_CLKS clocks after the programming-mode input rises sets a sticky error output, which only the system reset clears. The four-byte frame containing that rise has no effect.
- R12: While the programming-mode input is low, the output is 0, framing restarts and the enable is dropped. The lock level and the array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| prog_mode | input | 1 | Programming-mode input; high enables the serial port |
| sck | input | 1 | Serial shift clock from the programmer |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| busy | output | 1 | High while a self-timed erase or write runs |
| proto_err | output | 1 | Sticky flag for a too-early shift-clock edge |

## Verification
Two functions can land in the same cycle: a read instruction whose response byte is chosen while a self-timed write or erase is still counting. The response byte then has to come from the data-polling or erase-read path rather than from the array. The bench provokes this by issuing a read of the just-written address, and of a neighbouring address, straight after a byte write. It also issues a read straight after a chip erase. Each returned byte is compared with the value a bench function predicts from the busy window, the last written address and the model of the array.

// File: rtl/isp_pkg.sv
// Shared constants and types for the serial programming slave.
// Assumes 256-byte pages; the page count follows from the address width.
package isp_pkg;

    localparam logic [7:0] OP_SYS      = 8'hAC;   // enable, erase, lock write
    localparam logic [7:0] OP_ENA_KEY  = 8'h53;
    localparam logic [7:0] OP_RD_BYTE  = 8'h20;
    localparam logic [7:0] OP_WR_BYTE  = 8'h40;
    localparam logic [7:0] OP_RD_PAGE  = 8'h30;
    localparam logic [7:0] OP_WR_PAGE  = 8'h50;
    localparam logic [7:0] OP_RD_LOCK  = 8'h24;
    localparam logic [7:0] OP_RD_SIG   = 8'h28;
    localparam logic [7:0] ENA_ECHO    = 8'h69;

    typedef enum logic [2:0] {
        PH_OP,      // waiting for opcode byte
        PH_HI,      // waiting for address-high byte
        PH_LO,      // waiting for address-low byte
        PH_DAT,     // waiting for data byte
        PH_PAGE     // streaming 256 page bytes
    } phase_t;

    // Identity bytes, keyed on the 12-bit signature address.
    function automatic logic [7:0] sig_byte(input logic [11:0] a);
        case (a)
            12'h000: sig_byte = 8'h1E;
            12'h100: sig_byte = 8'h51;
            12'h200: sig_byte = 8'h06;
            default: sig_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/isp_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes each bit is independent; no bus coherence is implied.
module isp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/isp_shifter.sv
// Bit-level serial engine. It finds shift-clock edges, assembles received
// bytes, and shifts response bytes out MSB first after falling edges.
// Assumes tx_load arrives between a byte's last rise and the next fall.
module isp_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act,
    input  logic       sck_s,
    input  logic       mosi_s,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       sck_rise,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       miso
);
    logic       sck_q;
    logic       sck_fall;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sr;
    logic [7:0] tx_sr;

    // Keep the previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign sck_rise = act &  sck_s & ~sck_q;
    assign sck_fall = act & ~sck_s &  sck_q;

    // Receive bits on rising edges and flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !act) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (sck_rise) begin
                rx_sr   <= {rx_sr[6:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sr[6:0], mosi_s};
                end
            end
        end
    end

    // Load the response byte, then present one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !act) begin
            tx_sr <= '0;
            miso  <= 1'b0;
        end else if (tx_load) begin
            tx_sr <= tx_byte;
        end else if (sck_fall) begin
            miso  <= tx_sr[7];
            tx_sr <= {tx_sr[6:0], 1'b0};
        end
    end

    AST_MISO_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) !act |=> !miso);            // R12
    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) byte_done |=> !byte_done);  // R3
endmodule

// File: rtl/isp_flash_array.sv
// Behavioural code array: one synchronous write port, one combinational
// read port. It has no reset; its contents are undefined until erased.
module isp_flash_array #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Store one byte per strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/isp_engine.sv
// Instruction engine. It frames bytes into instructions and decodes them,
// gates access by the enable and lock state, and runs the self-timed
// write and erase counters. During an erase it sweeps the array to 0xFF.
// Assumes byte_done pulses for at most one cycle per received byte.
module isp_engine
    import isp_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WRITE_CYC  = 2000,
    parameter int ERASE_CYC  = 20000,
    parameter int GUARD_CLKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              sck_rise,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    output logic              tx_load,
    output logic [7:0]        tx_byte,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [7:0]        wdata,
    output logic              busy,
    output logic              err
);
    localparam int PG_W      = ADDR_W - 8;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int ERASE_LEN = (ERASE_CYC > DEPTH) ? ERASE_CYC : DEPTH;
    localparam int ECW       = $clog2(ERASE_LEN + 1);
    localparam int WCW       = $clog2(WRITE_CYC + 1);
    localparam int GCW       = $clog2(GUARD_CLKS + 1);
    localparam logic [ECW-1:0] DEPTH_E = ECW'(DEPTH);

    phase_t            ph;
    logic [7:0]        op, hi, lo, off;
    logic [PG_W-1:0]   page;
    logic              pg_wr, en_q, bad_q;
    logic [1:0]        lock_q;           // lock level minus one
    logic [GCW-1:0]    guard_cnt;
    logic              wr_busy, er_busy;
    logic [WCW-1:0]    wr_cnt;
    logic [ECW-1:0]    er_cnt;
    logic [ADDR_W-1:0] last_addr;

    logic       ok, is_ena, is_erase, is_lockw, bad_now;
    logic       cmd_we, wr_go, er_go, lk_go;
    logic [7:0] code_val, next_tx, lock_rd;

    assign busy     = wr_busy | er_busy;
    assign ok       = en_q & ~bad_q;
    assign is_ena   = (op == OP_SYS) && (hi == OP_ENA_KEY);
    assign is_erase = (op == OP_SYS) && (hi[7:5] == 3'b100);
    assign is_lockw = (op == OP_SYS) && (hi[7:2] == 6'b111000);
    assign bad_now  = sck_rise && (guard_cnt < GCW'(GUARD_CLKS));
    assign lock_rd  = {3'b000, lock_q == 2'd3, lock_q >= 2'd2, lock_q >= 2'd1, 2'b00};

    // Choose the read address for the byte about to be answered.
    always_comb begin
        case (ph)
            PH_HI:   rd_addr = {rx_byte[PG_W-1:0], 8'h00};
            PH_LO:   rd_addr = {hi[PG_W-1:0], rx_byte};
            PH_PAGE: rd_addr = {page, off + 8'd1};
            default: rd_addr = '0;
        endcase
    end

    // Code read value with the erase, lock and data-polling overrides.
    always_comb begin
        if (er_busy || lock_q >= 2'd2)             code_val = 8'h00;
        else if (wr_busy && rd_addr == last_addr)  code_val = rd_data ^ 8'h80;
        else                                       code_val = rd_data;
    end

    // Response byte for the next transmit slot.
    always_comb begin
        next_tx = 8'h00;
        case (ph)
            PH_HI:   if (ok && op == OP_RD_PAGE) next_tx = code_val;
            PH_LO:   if (!bad_q) begin
                         if (is_ena)                  next_tx = ENA_ECHO;
                         else if (en_q && op == OP_RD_BYTE) next_tx = code_val;
                         else if (en_q && op == OP_RD_LOCK) next_tx = lock_rd;
                         else if (en_q && op == OP_RD_SIG && lock_q < 2'd2)
                             next_tx = sig_byte(12'(rd_addr));
                     end
            PH_PAGE: if (!pg_wr && off != 8'hFF) next_tx = code_val;
            default: next_tx = 8'h00;
        endcase
    end

    // Execution strobes for the completed data byte.
    always_comb begin
        cmd_we = 1'b0;
        if (byte_done && !busy && lock_q == 2'd0) begin
            if (ph == PH_DAT && ok && op == OP_WR_BYTE) cmd_we = 1'b1;
            if (ph == PH_PAGE && pg_wr)                 cmd_we = 1'b1;
        end
    end
    assign wr_go = cmd_we && (ph == PH_DAT || off == 8'hFF);
    assign er_go = byte_done && ph == PH_DAT && ok && is_erase && !busy;
    assign lk_go = byte_done && ph == PH_DAT && ok && is_lockw && !busy;

    // Array write port: the erase sweep has the port while it runs.
    always_comb begin
        we    = 1'b0;
        waddr = '0;
        wdata = rx_byte;
        if (er_busy && er_cnt < DEPTH_E) begin
            we    = 1'b1;
            waddr = er_cnt[ADDR_W-1:0];
            wdata = 8'hFF;
        end else if (cmd_we) begin
            we    = 1'b1;
            waddr = (ph == PH_PAGE) ? {page, off} : {hi[PG_W-1:0], lo};
        end
    end

    // Byte framing, enable tracking and the early-clock guard.
    always_ff @(posedge clk) begin
        if (!rst_n || !act) begin
            ph        <= PH_OP;
            op        <= '0;
            hi        <= '0;
            lo        <= '0;
            off       <= '0;
            page      <= '0;
            pg_wr     <= 1'b0;
            en_q      <= 1'b0;
            bad_q     <= 1'b0;
            guard_cnt <= '0;
        end else begin
            if (guard_cnt < GCW'(GUARD_CLKS)) guard_cnt <= guard_cnt + 1'b1;
            if (bad_now) bad_q <= 1'b1;
            if (byte_done) begin
                case (ph)
                    PH_OP: begin
                        op <= rx_byte;
                        ph <= PH_HI;
                    end
                    PH_HI: begin
                        hi <= rx_byte;
                        if (ok && (op == OP_RD_PAGE || op == OP_WR_PAGE)) begin
                            ph    <= PH_PAGE;
                            page  <= rx_byte[PG_W-1:0];
                            off   <= '0;
                            pg_wr <= (op == OP_WR_PAGE);
                        end else begin
                            ph <= PH_LO;
                        end
                    end
                    PH_LO: begin
                        lo <= rx_byte;
                        ph <= PH_DAT;
                    end
                    PH_DAT: begin
                        if (!bad_q && is_ena) en_q <= 1'b1;
                        bad_q <= 1'b0;
                        ph    <= PH_OP;
                    end
                    default: begin
                        off <= off + 8'd1;
                        if (off == 8'hFF) ph <= PH_OP;
                    end
                endcase
            end
        end
    end

    // Register the response byte handed to the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_load <= 1'b0;
            tx_byte <= '0;
        end else begin
            tx_load <= byte_done;
            tx_byte <= next_tx;
        end
    end

    // Self-timed write and erase counters, lock level and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_busy   <= 1'b0;
            wr_cnt    <= '0;
            er_busy   <= 1'b0;
            er_cnt    <= '0;
            last_addr <= '0;
            lock_q    <= '0;
            err       <= 1'b0;
        end else begin
            if (act && bad_now) err <= 1'b1;
            if (wr_go) begin
                wr_busy   <= 1'b1;
                wr_cnt    <= WCW'(WRITE_CYC - 1);
                last_addr <= waddr;
            end else if (wr_busy) begin
                if (wr_cnt == '0) wr_busy <= 1'b0;
                else              wr_cnt  <= wr_cnt - 1'b1;
            end
            if (er_go) begin
                er_busy <= 1'b1;
                er_cnt  <= ECW'(ERASE_LEN - 1);
                lock_q  <= 2'd0;
            end else if (er_busy) begin
                if (er_cnt == '0) er_busy <= 1'b0;
                else              er_cnt  <= er_cnt - 1'b1;
            end
            if (lk_go && hi[1:0] > lock_q) lock_q <= hi[1:0];
        end
    end

    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({wr_busy, er_busy}));              // R7
    AST_ERR_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) $past(err) |-> err);                         // R11
    AST_LOCK_NO_DROP:   assert property (@(posedge clk) disable iff (!rst_n) (lock_q < $past(lock_q)) |-> $past(er_go)); // R8
    AST_ERASE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                             (byte_done && ph == PH_LO && er_busy && op == OP_RD_BYTE) |=> (tx_byte == 8'h00));           // R5
    AST_POLL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                             (byte_done && ph == PH_LO && ok && op == OP_RD_BYTE && lock_q == 2'd0 && !busy)
                             |=> (tx_byte == $past(rd_data)));                                                            // R6
endmodule

// File: rtl/isp_slave.sv
// Top level of the serial programming slave. It ties together the input
// synchroniser, the bit shifter, the instruction engine and the code array.
// Assumes the shift clock runs at no more than clk/16.
module isp_slave #(
    parameter int ADDR_W     = 12,
    parameter int WRITE_CYC  = 2000,
    parameter int ERASE_CYC  = 20000,
    parameter int GUARD_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_mode,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic busy,
    output logic proto_err
);
    logic [2:0]        sync_q;
    logic              sck_rise, byte_done, tx_load, we;
    logic [7:0]        rx_byte, tx_byte, rd_data, wdata;
    logic [ADDR_W-1:0] rd_addr, waddr;

    isp_sync #(.W(3), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({mosi, sck, prog_mode}),
        .q    (sync_q)
    );

    isp_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (sync_q[0]),
        .sck_s    (sync_q[1]),
        .mosi_s   (sync_q[2]),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .sck_rise (sck_rise),
        .byte_done(byte_done),
        .rx_byte  (rx_byte),
        .miso     (miso)
    );

    isp_engine #(
        .ADDR_W    (ADDR_W),
        .WRITE_CYC (WRITE_CYC),
        .ERASE_CYC (ERASE_CYC),
        .GUARD_CLKS(GUARD_CLKS)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (sync_q[0]),
        .sck_rise (sck_rise),
        .byte_done(byte_done),
        .rx_byte  (rx_byte),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .busy     (busy),
        .err      (proto_err)
    );

    isp_flash_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk  (clk),
        .we   (we),
        .waddr(waddr),
        .wdata(wdata),
        .raddr(rd_addr),
        .rdata(rd_data)
    );
endmodule

// File: tb/isp_slave_tb.sv
`timescale 1ns/1ps
module isp_slave_tb;
    localparam int HALF = 8;       // shift clock = clk/16
    localparam int WCYC = 2000;
    localparam int ECYC = 4500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_mode = 1'b0;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, busy, proto_err;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] model [4096];

    always #2 clk = ~clk;

    isp_slave #(.ADDR_W(12), .WRITE_CYC(WCYC), .ERASE_CYC(ECYC), .GUARD_CLKS(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .sck(sck),
        .mosi(mosi), .miso(miso), .busy(busy), .proto_err(proto_err)
    );

    function automatic logic [7:0] sig_exp(input logic [11:0] a);
        return (a == 12'h000) ? 8'h1E : (a == 12'h100) ? 8'h51 : (a == 12'h200) ? 8'h06 : 8'h00;
    endfunction

    function automatic logic [7:0] lock_exp(input int level);
        return {3'b000, level >= 4, level >= 3, level >= 2, 2'b00};
    endfunction

    function automatic logic [7:0] poll_exp(input logic [7:0] d);
        return {~d[7], d[6:0]};
    endfunction

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] o, output logic [7:0] r);
        r = 8'h00;
        for (int b = 7; b >= 0; b--) begin
            mosi = o[b];
            waitc(HALF);
            r[b] = miso;
            sck = 1'b1;
            waitc(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cmd(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input logic [7:0] d, output logic [7:0] r);
        logic [7:0] t;
        xfer(a, t); xfer(b, t); xfer(c, t); xfer(d, r);
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] r);
        cmd(8'h20, {4'h0, a[11:8]}, a[7:0], 8'h00, r);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        logic [7:0] t;
        cmd(8'h40, {4'h0, a[11:8]}, a[7:0], d, t);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 6000 && busy; i++) waitc(1);
    endtask

    task automatic enter_mode();
        prog_mode = 1'b1;
        waitc(100);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [7:0] r, t;
        logic [11:0] a;
        logic [3:0] pg;
        int bad;
        void'($urandom(32'd20240611));
        waitc(5);
        check("R12 reset miso", {7'd0, miso}, 8'h00);
        check("R12 reset busy", {7'd0, busy}, 8'h00);
        check("R11 reset err", {7'd0, proto_err}, 8'h00);
        rst_n = 1'b1;
        waitc(5);
        enter_mode();

        // R1: lock write and read before enable have no effect
        cmd(8'hAC, 8'hE3, 8'h00, 8'h00, t);
        rd(12'h123, r);
        check("R1 read before enable", r, 8'h00);

        // R2: enable echo
        cmd(8'hAC, 8'h53, 8'h00, 8'h00, r);
        check("R2 enable echo", r, 8'h69);
        cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R1 lock untouched before enable", r, lock_exp(1));

        // R5: erase, busy, read during erase
        cmd(8'hAC, 8'h80, 8'h00, 8'h00, t);
        check("R5 busy after erase", {7'd0, busy}, 8'h01);
        rd(12'h123, r);
        check("R5 read during erase", r, 8'h00);
        wait_idle();
        for (int i = 0; i < 4096; i++) model[i] = 8'hFF;
        rd(12'h123, r);
        check("R5 erased value", r, 8'hFF);

        // R6/R7: data polling and write while busy
        wr(12'h123, 8'hA5);
        check("R6 busy after write", {7'd0, busy}, 8'h01);
        wr(12'h124, 8'h00);
        rd(12'h123, r);
        check("R6 polling value", r, poll_exp(8'hA5));
        rd(12'h124, r);
        check("R6 other address during write", r, 8'hFF);
        wait_idle();
        model[12'h123] = 8'hA5;
        rd(12'h123, r);
        check("R6 value after write", r, 8'hA5);
        rd(12'h124, r);
        check("R7 write during busy ignored", r, model[12'h124]);

        // R3: random byte writes and reads
        for (int k = 0; k < 6; k++) begin
            a = 12'($urandom_range(0, 4095));
            t = 8'($urandom_range(0, 255));
            wr(a, t);
            model[a] = t;
            wait_idle();
            rd(a, r);
            check("R3 random byte", r, model[a]);
        end

        // R4: page write then page read
        pg = 4'($urandom_range(0, 15));
        xfer(8'h50, t); xfer({4'h0, pg}, t);
        for (int i = 0; i < 256; i++) begin
            model[{pg, 8'(i)}] = 8'($urandom_range(0, 255));
            xfer(model[{pg, 8'(i)}], t);
        end
        wait_idle();
        bad = 0;
        xfer(8'h30, t); xfer({4'h0, pg}, t);
        for (int i = 0; i < 256; i++) begin
            xfer(8'h00, r);
            if (r !== model[{pg, 8'(i)}]) bad++;
        end
        check("R4 page mismatches", 8'(bad), 8'h00);
        rd({pg, 8'h11}, r);
        check("R4 framing after page", r, model[{pg, 8'h11}]);

        // R10: signatures
        for (int s = 0; s < 4; s++) begin
            a = {2'b00, 2'(s), 8'h00};
            cmd(8'h28, {4'h0, a[11:8]}, a[7:0], 8'h00, r);
            check("R10 signature", r, sig_exp(a));
        end

        // R8/R9: lock levels
        cmd(8'hAC, 8'hE1, 8'h00, 8'h00, t);
        cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R8 lock level 2", r, lock_exp(2));
        wr(12'h010, 8'h33);
        check("R9 no busy when locked", {7'd0, busy}, 8'h00);
        rd(12'h010, r);
        check("R9 write ignored at level 2", r, model[12'h010]);
        cmd(8'hAC, 8'hE0, 8'h00, 8'h00, t);
        cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R8 lock does not drop", r, lock_exp(2));
        cmd(8'hAC, 8'hE2, 8'h00, 8'h00, t);
        cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R8 lock level 3", r, lock_exp(3));
        rd(12'h123, r);
        check("R9 code read blocked", r, 8'h00);
        cmd(8'h28, 8'h00, 8'h00, 8'h00, r);
        check("R9 signature blocked", r, 8'h00);
        cmd(8'hAC, 8'hE3, 8'h00, 8'h00, t);
        cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R8 lock level 4", r, lock_exp(4));

        // R12: leaving programming mode
        prog_mode = 1'b0;
        waitc(10);
        check("R12 miso low when inactive", {7'd0, miso}, 8'h00);
        enter_mode();
        cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R12 enable dropped", r, 8'h00);
        cmd(8'hAC, 8'h53, 8'h00, 8'h00, r);
        check("R2 enable again", r, 8'h69);
        cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R12 lock kept", r, lock_exp(4));

        // R5: erase clears the lock level
        cmd(8'hAC, 8'h9F, 8'h00, 8'h00, t);
        wait_idle();
        cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R5 lock cleared by erase", r, lock_exp(1));
        rd(12'h123, r);
        check("R5 array erased", r, 8'hFF);

        // R11: early clock edge
        prog_mode = 1'b0;
        waitc(10);
        prog_mode = 1'b1;
        waitc(4);
        cmd(8'hAC, 8'h53, 8'h00, 8'h00, r);
        check("R11 bad frame no echo", r, 8'h00);
        check("R11 error set", {7'd0, proto_err}, 8'h01);
        rd(12'h123, r);
        check("R11 bad frame did not enable", r, 8'h00);
        cmd(8'hAC, 8'h53, 8'h00, 8'h00, r);
        check("R11 later enable works", r, 8'h69);
        check("R11 error sticky", {7'd0, proto_err}, 8'h01);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule